// File: doc/BRIEF.md
# Byte-Lane Pipelined Burst Memory Datapath

This block is the storage and data path of a synchronous burst memory. A burst controller in front of it hands over, each cycle, an access request with a word address. The block stores words made of 9-bit byte lanes, and each lane carries eight data bits plus one parity bit. The write lanes come from a priority decode. A global write strobe takes precedence over a byte-write enable, and the byte-write enable takes precedence over the per-lane strobes. A request that writes no lane is a read. Read data passes through two registers before it reaches the output bus.

The block also computes the enable for the external tri-state data drivers. The asynchronous output-enable input, the sleep input, a recent write and a staged chip-select pipeline can each force that enable low. While sleep is high the stored contents are kept and requests are dropped. After sleep falls, a fixed lockout of two cycles passes before requests are accepted again. The `start_ok` output tells the controller when requests may be issued.

Top module: `bwd_burst_datapath`

## Requirements
- R1: With `gw_n` low, a request writes every lane of the word at `acc_addr`, whatever `bwe_n` and `lane_we_n` are.
- R2: With `gw_n` high and `bwe_n` low, a request writes only the lanes whose `lane_we_n` bit is low. Lane i is bits 9i+8..9i of the word, and bit 9i+8 is its parity. The other lanes keep their contents.
- R3: With `gw_n` high, `bwe_n` low and every `lane_we_n` bit high, a request is a read and changes no stored data.
- R4: With `gw_n` and `bwe_n` both high, a request is a read whatever `lane_we_n` is.
- R5: A read accepted on clock edge k presents the stored word on `rdata` after edge k+1.
- R6: After an edge that performed a write, `drive_en` is low for the following cycle, whatever `oe_n` is.
- R7: `oe_n` acts without a clock: while it is high, `drive_en` is low in the same cycle.
- R8: While `sleep` is high, `drive_en` is low at once, requests are ignored and stored data is kept.
- R9: After `sleep` returns low, requests on the first two edges are ignored. `start_ok` is low while sleep or the lockout is active, and high otherwise.
- R10: `drive_en` can be high only after `sel` has been sampled high on two consecutive edges. It goes low after a single edge that samples `sel` low.
- R11: During and right after reset, `drive_en` is low, no read data is pending and `start_ok` is high.

Top module ports are listed in order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access request from the burst controller this cycle |
| acc_addr | input | AW | Word address of the request |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| wdata | input | LANES*9 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| sel | input | 1 | Chip selected, sampled each edge |
| rdata | output | LANES*9 | Registered read data |
| drive_en | output | 1 | Enable for external tri-state data drivers |
| start_ok | output | 1 | High when new requests are accepted |

## Verification
The bench keeps a shadow copy of the array and a cycle model of the pipeline, and compares its predictions with the design every cycle. It uses one address for a full write, a masked write to one lane, a read with every strobe high and a read with byte-write disabled. A design with the wrong decode priority would corrupt the untouched lane, and the following reads would return the wrong value.

It drops `oe_n` and raises `sleep` in the middle of a cycle. A design that registered either input would leave the drivers on for a cycle too long. It also issues writes during sleep and during the two lockout cycles. A lockout that is too short would commit one of those writes, and the read that follows would show it.

Short gaps in `sel` check the staged enable. A design that enabled the drivers after only one edge of selection would drive the bus too early.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    localparam int unsigned LANE_BITS = 9;
    localparam int unsigned WAKE_LOCK = 2;
endpackage

// File: rtl/bwd_write_decode.sv
module bwd_write_decode #(
    parameter int unsigned LANES = 2
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] wr_mask
);
    always_comb begin
        if (!gw_n) begin
            wr_mask = '1;
        end else if (!bwe_n) begin
            wr_mask = ~lane_we_n;
        end else begin
            wr_mask = '0;
        end
    end
endmodule

// File: rtl/bwd_lane_array.sv
module bwd_lane_array #(
    parameter int unsigned LANES = 2,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LW = bwd_pkg::LANE_BITS,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned WW = LANES * LW
) (
    input  logic             clk,
    input  logic             wr_fire,
    input  logic [LANES-1:0] wr_mask,
    input  logic [AW-1:0]    addr,
    input  logic [WW-1:0]    wdata,
    output logic [WW-1:0]    rd_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] store_q [DEPTH];
        logic          lane_we;

        always_comb begin
            lane_we = wr_fire && wr_mask[g];
        end

        always_ff @(posedge clk) begin
            if (lane_we) begin
                store_q[addr] <= wdata[g*LW +: LW];
            end
        end

        always_comb begin
            rd_word[g*LW +: LW] = store_q[addr];
        end
    end
endmodule

// File: rtl/bwd_read_pipe.sv
module bwd_read_pipe #(
    parameter int unsigned WW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_fire,
    input  logic [WW-1:0] rd_word,
    output logic [WW-1:0] out_data,
    output logic          out_vld
);
    typedef struct packed {
        logic [WW-1:0] stage_data;
        logic          stage_vld;
        logic [WW-1:0] out_data;
        logic          out_vld;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.out_data = st_q.stage_data;
        st_d.out_vld  = st_q.stage_vld;
        st_d.stage_vld = rd_fire;
        if (rd_fire) begin
            st_d.stage_data = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.out_data;
    assign out_vld  = st_q.out_vld;
endmodule

// File: rtl/bwd_drive_ctrl.sv
module bwd_drive_ctrl #(
    parameter int unsigned WAKE_CYC = bwd_pkg::WAKE_LOCK,
    localparam int unsigned CW = $clog2(WAKE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic sel,
    input  logic wr_fire,
    input  logic out_vld,
    input  logic oe_n,
    output logic lock,
    output logic drive_en
);
    typedef struct packed {
        logic [CW-1:0] wake_cnt;
        logic          sel_a;
        logic          sel_b;
        logic          wr_seen;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d.wake_cnt = CW'(WAKE_CYC);
        end else if (st_q.wake_cnt != '0) begin
            st_d.wake_cnt = st_q.wake_cnt - 1'b1;
        end
        st_d.sel_a   = sel;
        st_d.sel_b   = st_q.sel_a;
        st_d.wr_seen = wr_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        lock     = sleep || (st_q.wake_cnt != '0);
        drive_en = out_vld && !oe_n && !sleep && !st_q.wr_seen
                   && st_q.sel_a && st_q.sel_b;
    end

    assert_sel_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !drive_en);
endmodule

// File: rtl/bwd_burst_datapath.sv
module bwd_burst_datapath #(
    parameter int unsigned LANES = 2,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned WW = LANES * bwd_pkg::LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [AW-1:0]    acc_addr,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic [WW-1:0]    wdata,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic             sel,
    output logic [WW-1:0]    rdata,
    output logic             drive_en,
    output logic             start_ok
);
    logic [LANES-1:0] wr_mask;
    logic [WW-1:0]    rd_word;
    logic             lock;
    logic             out_vld;
    logic             take;
    logic             wr_fire;
    logic             rd_fire;

    bwd_write_decode #(.LANES(LANES)) u_dec (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .lane_we_n (lane_we_n),
        .wr_mask   (wr_mask)
    );

    always_comb begin
        take    = acc_valid && !lock;
        wr_fire = take && (wr_mask != '0);
        rd_fire = take && (wr_mask == '0);
    end

    bwd_lane_array #(.LANES(LANES), .DEPTH(DEPTH)) u_arr (
        .clk     (clk),
        .wr_fire (wr_fire),
        .wr_mask (wr_mask),
        .addr    (acc_addr),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    bwd_read_pipe #(.WW(WW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .rd_word  (rd_word),
        .out_data (rdata),
        .out_vld  (out_vld)
    );

    bwd_drive_ctrl u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .sel      (sel),
        .wr_fire  (wr_fire),
        .out_vld  (out_vld),
        .oe_n     (oe_n),
        .lock     (lock),
        .drive_en (drive_en)
    );

    assign start_ok = !lock;

    assert_global_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |-> (&wr_mask));
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(rd_fire, 2));
    assert_write_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_fire) |-> !drive_en);
    assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!wr_fire && !drive_en));
    assert_wake_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> !start_ok);
endmodule

// File: tb/tb_bwd_burst_datapath.sv
module tb_bwd_burst_datapath;
    localparam int LANES = 2;
    localparam int DEPTH = 64;
    localparam int AW = 6;
    localparam int WW = 18;

    logic clk = 0;
    logic rst_n = 0;
    logic acc_valid = 0;
    logic [AW-1:0] acc_addr = '0;
    logic gw_n = 1, bwe_n = 1;
    logic [LANES-1:0] lane_we_n = '1;
    logic [WW-1:0] wdata = '0;
    logic oe_n = 0, sleep = 0, sel = 1;
    logic [WW-1:0] rdata;
    logic drive_en, start_ok;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R11";

    logic [WW-1:0] mem [DEPTH];
    logic [WW-1:0] m_s1 = '0, m_out = '0;
    bit m_s1v = 0, m_outv = 0, m_sel1 = 0, m_sel2 = 0, m_wrs = 0;
    int m_wake = 0;

    always #4 clk = ~clk;

    bwd_burst_datapath #(.LANES(LANES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .sel(sel), .rdata(rdata),
        .drive_en(drive_en), .start_ok(start_ok));

    task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [1:0] wl;
        bit lk, wr, rd;
        if (!rst_n) begin
            m_s1v = 0; m_outv = 0; m_sel1 = 0; m_sel2 = 0; m_wrs = 0; m_wake = 0;
            m_s1 = '0; m_out = '0;
            return;
        end
        lk = sleep || (m_wake != 0);
        wl = !gw_n ? 2'b11 : (!bwe_n ? ~lane_we_n : 2'b00);
        wr = acc_valid && !lk && (wl != 0);
        rd = acc_valid && !lk && (wl == 0);
        m_out = m_s1; m_outv = m_s1v;
        if (rd) m_s1 = mem[acc_addr];
        m_s1v = rd;
        if (wr) begin
            for (int i = 0; i < LANES; i++)
                if (wl[i]) mem[acc_addr][i*9 +: 9] = wdata[i*9 +: 9];
        end
        m_wrs = wr;
        m_sel2 = m_sel1; m_sel1 = sel;
        m_wake = sleep ? 2 : (m_wake > 0 ? m_wake - 1 : 0);
    endtask

    task automatic compare();
        bit ed;
        ed = m_outv && !oe_n && !m_wrs && m_sel1 && m_sel2 && !sleep;
        check({cur_req, " drive_en"}, WW'(drive_en), WW'(ed));
        check({cur_req, " start_ok"}, WW'(start_ok), WW'(!sleep && m_wake == 0));
        if (ed) check({cur_req, " rdata"}, rdata, m_out);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic req(input bit v, input int a, input bit g, input bit b,
                       input logic [1:0] ln, input logic [WW-1:0] d);
        acc_valid = v; acc_addr = AW'(a); gw_n = g; bwe_n = b; lane_we_n = ln; wdata = d;
        cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) req(0, 0, 1, 1, 2'b11, '0);
    endtask

    task automatic rd(input int a);
        req(1, a, 1, 1, 2'b11, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R11";
        repeat (3) cyc();
        check("R11 reset drive_en", WW'(drive_en), '0);
        check("R11 reset start_ok", WW'(start_ok), WW'(1'b1));
        @(negedge clk) rst_n = 1;
        idle(2);

        cur_req = "R1";
        req(1, 3, 0, 1, 2'b11, 18'h2ABCD);
        req(1, 5, 0, 0, 2'b00, 18'h13579);
        rd(3); rd(5); idle(2);

        cur_req = "R6";
        rd(5); req(1, 7, 0, 1, 2'b11, 18'h0F0F0); idle(1);
        oe_n = 1; rd(3); req(1, 8, 0, 1, 2'b11, 18'h11111); oe_n = 0; idle(2);

        cur_req = "R2";
        req(1, 3, 1, 0, 2'b10, 18'h3FE55);
        rd(3); idle(2);
        req(1, 5, 1, 0, 2'b01, 18'h2AA00);
        rd(5); idle(2);

        cur_req = "R3";
        req(1, 3, 1, 0, 2'b11, 18'h00000);
        idle(2); rd(3); idle(2);

        cur_req = "R4";
        req(1, 5, 1, 1, 2'b00, 18'h00000);
        idle(2); rd(5); idle(2);

        cur_req = "R5";
        rd(7); rd(3); rd(5); rd(7); idle(3);

        cur_req = "R7";
        rd(3); idle(1);
        check("R7 drive on", WW'(drive_en), WW'(1'b1));
        #1 oe_n = 1;
        #1 check("R7 oe_n high async", WW'(drive_en), '0);
        oe_n = 0;
        #1 check("R7 oe_n low async", WW'(drive_en), WW'(1'b1));
        idle(1);

        cur_req = "R8";
        rd(3); idle(1);
        #1 sleep = 1;
        #1 check("R8 sleep async", WW'(drive_en), '0);
        req(1, 3, 0, 1, 2'b11, 18'h00001);
        req(1, 5, 0, 1, 2'b11, 18'h00002);
        sleep = 0;
        cur_req = "R9";
        req(1, 3, 0, 1, 2'b11, 18'h00003);
        req(1, 5, 0, 1, 2'b11, 18'h00004);
        req(1, 7, 0, 1, 2'b11, 18'h00005);
        rd(3); rd(5); rd(7); idle(3);

        cur_req = "R10";
        sel = 0; rd(3); sel = 1; idle(1);
        rd(5); idle(1); sel = 0; idle(1); sel = 1; rd(7); idle(3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule